// File: doc/BRIEF.md
# Direct-Mapped Cache over a Pipelined Fixed-Latency Memory

This block is a direct-mapped cache that serves word and byte loads and stores from a processor pipeline. Behind it sits a memory model that accepts one request in every cycle. Each read comes back a fixed number of cycles after it was issued, tagged with an identifier. A lookup that hits finishes in the cycle the request is presented. A lookup that misses stalls the pipeline while the line is refilled. The refill issues one read per word of the line in back-to-back cycles, so the reads overlap in the memory pipeline. Once the whole line is present, the stalled access completes as a hit.

Stores are write-through with write-allocate. A store that hits updates the addressed bytes of the cached line and sends the same write to memory in the same cycle. A store that misses first refills the line and then proceeds as a store hit. The pipeline presents one access with `cpu_valid` and holds it stable until `cpu_done`. Word accesses must be aligned. Byte accesses may use any lane.

With the default parameters the cache has 8 lines of 4 words each, a 10-bit byte address and 5 memory wait cycles.

Top module: `dmc_cache`

## Requirements
- R1: After reset, no line is valid, `cpu_stall` and `cpu_done` are low while no request is presented, and the first access to any address misses.
- R2: An access whose line is valid and whose tag matches completes in the cycle it is presented. In that cycle `cpu_done` and `cpu_hit` are high and `cpu_stall` is low, and a word load returns the stored word.
- R3: On a miss, `cpu_miss` and `cpu_stall` are high in the request cycle. The access completes exactly LINE_WORDS + MEM_WAIT + 2 cycles after the request cycle (11 with the defaults), and in that cycle `cpu_hit` is low.
- R4: Memory responses return in issue order, each MEM_WAIT + 1 cycles after its request. Each response carries the word offset it belongs to. The memory never holds more reads in flight than its pipeline depth.
- R5: The address splits into bits [1:0] byte lane, [3:2] word in line, [6:4] line index and [9:7] tag. Two addresses with the same index and different tags evict each other. Addresses with different indices stay resident together.
- R6: A byte load returns the byte in lane addr[1:0], taken from bits 8*lane+7 down to 8*lane of the word, sign-extended to 32 bits.
- R7: A byte store changes only the addressed byte. The other three bytes of the word, and the other words of the line, read back unchanged.
- R8: Stores reach memory. Data stored to a line reads back correctly after that line has been evicted and refilled.
- R9: For word accesses, address bits [1:0] are ignored.
- R10: `cpu_stall` is high in every cycle of an access before its completion cycle, and `cpu_done` and `cpu_stall` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_byte | input | 1 | 1 for byte access, 0 for word access |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data; a byte store uses bits [7:0] |
| cpu_rdata | output | 32 | Load result, valid with `cpu_done` |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | Completing access needed no refill |
| cpu_miss | output | 1 | Lookup missed this cycle; refill starts |
| cpu_stall | output | 1 | Pipeline must hold the current access |

## Verification
A wrong valid bit or tag shows up at once as a hit where a miss was expected, or the reverse. That changes the completion cycle by eleven cycles and flips `cpu_hit`, so it is caught on the same access. A refill word written to the wrong offset, or a lost write-through, stays hidden until that word is loaded or the line is refilled. The bench therefore reloads words of the same line and forces evictions soon after stores. A wrong lane choice or missing sign extension shows directly in the load data of the byte concerned.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;

  // Byte of a word picked by lane, sign-extended to a full word.
  function automatic logic [31:0] byte_load(input logic [31:0] w, input logic [1:0] lane);
    logic [7:0] b;
    b = w[lane*8 +: 8];
    return {{24{b[7]}}, b};
  endfunction

  // Byte-lane enables for a store of the given size.
  function automatic logic [3:0] lane_mask(input logic is_byte, input logic [1:0] lane);
    return is_byte ? (4'b0001 << lane) : 4'b1111;
  endfunction

  // Store data laid out so that any enabled lane picks the right byte.
  function automatic logic [31:0] store_data(input logic is_byte, input logic [31:0] w);
    return is_byte ? {4{w[7:0]}} : w;
  endfunction

  // Power-on content of memory word widx.
  function automatic logic [31:0] mem_seed(input logic [31:0] widx);
    logic [7:0] a;
    a = widx[7:0];
    return {a, ~a, a ^ 8'hC3, a + 8'h11};
  endfunction

endpackage

// File: rtl/dmc_mem_model.sv
module dmc_mem_model #(
  parameter int WADDR_W  = 8,
  parameter int MEM_WAIT = 5,
  parameter int ID_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  input  logic [ID_W-1:0]    req_id,
  output logic               resp_valid,
  output logic [31:0]        resp_data,
  output logic [ID_W-1:0]    resp_id
);
  import dmc_pkg::*;

  localparam int MEM_WORDS = 1 << WADDR_W;
  localparam int DEPTH     = MEM_WAIT + 1;
  localparam int CNT_W     = $clog2(DEPTH + 2);

  logic [31:0]     mem_q [MEM_WORDS];
  logic            pv_q  [DEPTH];
  logic [31:0]     pd_q  [DEPTH];
  logic [ID_W-1:0] pi_q  [DEPTH];

  logic rd_issue;
  assign rd_issue = req_valid && !req_we;

  // Storage: writes land at the sampling edge; reads sample the array there.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem_q[i] <= mem_seed(32'(i));
    end else if (req_valid && req_we) begin
      for (int l = 0; l < 4; l++)
        if (req_be[l]) mem_q[req_addr][l*8 +: 8] <= req_wdata[l*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pv_q[0] <= 1'b0;
    else        pv_q[0] <= rd_issue;
    pd_q[0] <= mem_q[req_addr];
    pi_q[0] <= req_id;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pv_q[g] <= 1'b0;
      else        pv_q[g] <= pv_q[g-1];
      pd_q[g] <= pd_q[g-1];
      pi_q[g] <= pi_q[g-1];
    end
  end

  assign resp_valid = pv_q[DEPTH-1];
  assign resp_data  = pd_q[DEPTH-1];
  assign resp_id    = pi_q[DEPTH-1];

  // Reads in flight, for the checks below.
  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_q + CNT_W'(rd_issue) - CNT_W'(resp_valid);
  end

  assert_inflight_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CNT_W'(DEPTH));
  assert_resp_has_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> inflight_q != '0);

endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] lk_idx,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     lk_hit,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic                     wr_valid
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_q[g] <= wr_valid;
        tag_q[g]   <= wr_tag;
      end
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  assert_clean_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> valid_q == '0);

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(LINES)-1:0]      rd_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] rd_off,
  output logic [31:0]                   rd_data,
  input  logic                          wr_en,
  input  logic [$clog2(LINES)-1:0]      wr_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_off,
  input  logic [3:0]                    wr_be,
  input  logic [31:0]                   wr_data
);
  localparam int WORDS = LINES * LINE_WORDS;

  logic [31:0] arr_q [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < 4; l++)
        if (wr_be[l]) arr_q[{wr_idx, wr_off}][l*8 +: 8] <= wr_data[l*8 +: 8];
    end
  end

  assign rd_data = arr_q[{rd_idx, rd_off}];

  // A write covers either one byte lane or the whole word.
  assert_lane_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_be == 4'hF || $countones(wr_be) == 1));

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W     = 10,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4,
  parameter int MEM_WAIT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic              cpu_byte,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              cpu_miss,
  output logic              cpu_stall
);
  import dmc_pkg::*;

  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - 2 - OFF_W - IDX_W;
  localparam int WADDR_W = ADDR_W - 2;
  localparam int CNT_W   = OFF_W + 1;

  // Address fields.
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] lk_idx;
  logic [OFF_W-1:0] lk_off;
  logic [1:0]       lk_lane;
  assign lk_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign lk_idx  = cpu_addr[2+OFF_W +: IDX_W];
  assign lk_off  = cpu_addr[2 +: OFF_W];
  assign lk_lane = cpu_addr[1:0];

  fill_state_e      state_q;
  logic [CNT_W-1:0] iss_cnt_q;
  logic [CNT_W-1:0] rx_cnt_q;
  logic [TAG_W-1:0] fill_tag_q;
  logic [IDX_W-1:0] fill_idx_q;
  logic             refill_q;

  // Named internal events.
  logic lk_hit;
  logic fill_issue;
  logic fill_last;

  logic               mreq_valid, mreq_we;
  logic [WADDR_W-1:0] mreq_addr;
  logic [3:0]         mreq_be;
  logic [31:0]        mreq_wdata;
  logic [OFF_W-1:0]   mreq_id;
  logic               mresp_valid;
  logic [31:0]        mresp_data;
  logic [OFF_W-1:0]   mresp_id;

  logic [31:0] rd_word;

  assign cpu_done   = (state_q == ST_IDLE) && cpu_valid && lk_hit;
  assign cpu_miss   = (state_q == ST_IDLE) && cpu_valid && !lk_hit;
  assign cpu_stall  = (state_q == ST_FILL) || cpu_miss;
  assign cpu_hit    = cpu_done && !refill_q;
  assign cpu_rdata  = cpu_byte ? byte_load(rd_word, lk_lane) : rd_word;

  assign fill_issue = (state_q == ST_FILL) && (iss_cnt_q < CNT_W'(LINE_WORDS));
  assign fill_last  = mresp_valid && (rx_cnt_q == CNT_W'(LINE_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      iss_cnt_q  <= '0;
      rx_cnt_q   <= '0;
      fill_tag_q <= '0;
      fill_idx_q <= '0;
      refill_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cpu_miss) begin
            state_q    <= ST_FILL;
            iss_cnt_q  <= '0;
            rx_cnt_q   <= '0;
            fill_tag_q <= lk_tag;
            fill_idx_q <= lk_idx;
            refill_q   <= 1'b1;
          end else if (cpu_done) begin
            refill_q   <= 1'b0;
          end
        end
        ST_FILL: begin
          if (fill_issue)  iss_cnt_q <= iss_cnt_q + 1'b1;
          if (mresp_valid) rx_cnt_q  <= rx_cnt_q + 1'b1;
          if (fill_last)   state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Memory request: refill reads while filling, write-through otherwise.
  always_comb begin
    if (state_q == ST_FILL) begin
      mreq_valid = fill_issue;
      mreq_we    = 1'b0;
      mreq_addr  = {fill_tag_q, fill_idx_q, iss_cnt_q[OFF_W-1:0]};
      mreq_be    = 4'hF;
      mreq_wdata = '0;
      mreq_id    = iss_cnt_q[OFF_W-1:0];
    end else begin
      mreq_valid = cpu_done && cpu_we;
      mreq_we    = 1'b1;
      mreq_addr  = cpu_addr[ADDR_W-1:2];
      mreq_be    = lane_mask(cpu_byte, lk_lane);
      mreq_wdata = store_data(cpu_byte, cpu_wdata);
      mreq_id    = '0;
    end
  end

  // Tag write: invalidate on miss, validate after the last refill word.
  logic             tw_en, tw_valid;
  logic [IDX_W-1:0] tw_idx;
  logic [TAG_W-1:0] tw_tag;
  assign tw_en    = cpu_miss || fill_last;
  assign tw_valid = fill_last;
  assign tw_idx   = fill_last ? fill_idx_q : lk_idx;
  assign tw_tag   = fill_last ? fill_tag_q : lk_tag;

  // Data write: refill words, or store-hit bytes.
  logic             dw_en;
  logic [IDX_W-1:0] dw_idx;
  logic [OFF_W-1:0] dw_off;
  logic [3:0]       dw_be;
  logic [31:0]      dw_data;
  always_comb begin
    if (state_q == ST_FILL) begin
      dw_en   = mresp_valid;
      dw_idx  = fill_idx_q;
      dw_off  = mresp_id;
      dw_be   = 4'hF;
      dw_data = mresp_data;
    end else begin
      dw_en   = cpu_done && cpu_we;
      dw_idx  = lk_idx;
      dw_off  = lk_off;
      dw_be   = lane_mask(cpu_byte, lk_lane);
      dw_data = store_data(cpu_byte, cpu_wdata);
    end
  end

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .wr_en(tw_en), .wr_idx(tw_idx), .wr_tag(tw_tag), .wr_valid(tw_valid)
  );

  dmc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_off(lk_off), .rd_data(rd_word),
    .wr_en(dw_en), .wr_idx(dw_idx), .wr_off(dw_off), .wr_be(dw_be), .wr_data(dw_data)
  );

  dmc_mem_model #(.WADDR_W(WADDR_W), .MEM_WAIT(MEM_WAIT), .ID_W(OFF_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .req_valid(mreq_valid), .req_we(mreq_we), .req_addr(mreq_addr),
    .req_be(mreq_be), .req_wdata(mreq_wdata), .req_id(mreq_id),
    .resp_valid(mresp_valid), .resp_data(mresp_data), .resp_id(mresp_id)
  );

  // Refill responses arrive in issue order, only while filling.
  assert_fill_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mresp_valid |-> (state_q == ST_FILL) && (mresp_id == rx_cnt_q[OFF_W-1:0]));
  // Every word of the line was requested before the line turns valid.
  assert_all_issued_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |-> iss_cnt_q == CNT_W'(LINE_WORDS));
  // With the request held, the line hits right after the refill ends.
  assert_hit_after_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_last && cpu_valid) |=> lk_hit);
  assert_done_not_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !cpu_stall);

endmodule

// File: tb/dmc_cache_tb.sv
`timescale 1ns/1ps
module dmc_cache_tb;

  localparam int ADDR_W = 10;
  localparam int NLINES = 8;
  localparam int LWORDS = 4;
  localparam int WAITC  = 5;
  localparam int MISS_LAT = LWORDS + WAITC + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic cpu_done, cpu_hit, cpu_miss, cpu_stall;

  always #2.5 clk = ~clk;

  dmc_cache #(.ADDR_W(ADDR_W), .LINES(NLINES), .LINE_WORDS(LWORDS), .MEM_WAIT(WAITC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_byte(cpu_byte),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .cpu_hit(cpu_hit), .cpu_miss(cpu_miss), .cpu_stall(cpu_stall)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] ref_mem [256];
  bit          ref_v [NLINES];
  int          ref_t [NLINES];

  function automatic logic [31:0] seed_word(int w);
    return 32'((w << 24) | ((255 - w) << 16) | ((w ^ 195) << 8) | ((w + 17) & 255));
  endfunction

  function automatic logic [31:0] sext8(logic [31:0] w, int lane);
    int b;
    b = int'((w >> (8 * lane)) & 32'hFF);
    if (b >= 128) b = b - 256;
    return 32'(b);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One access: predicts hit/miss, latency and load data from the reference model.
  task automatic do_acc(input bit we, input bit isb, input int addr, input logic [31:0] wd,
                        input string rq);
    int idx, tg, widx, lane, n;
    bit exp_hit, saw_miss, stall_ok;
    logic [31:0] exp_data;
    idx  = (addr / 16) % NLINES;
    tg   = addr / 128;
    widx = addr / 4;
    lane = addr % 4;
    exp_hit = ref_v[idx] && (ref_t[idx] == tg);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_byte = isb;
    cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
    #1;
    saw_miss = cpu_miss;
    stall_ok = 1'b1;
    n = 0;
    while (!cpu_done && n < 100) begin
      if (!cpu_stall) stall_ok = 1'b0;
      @(negedge clk); #1;
      n++;
    end
    if (n >= 100) begin
      chk(1'b0, "watchdog access", 32'(n), 32'(MISS_LAT));
      return;
    end
    if (exp_hit) begin
      chk(n == 0, "R2 hit latency", 32'(n), 0);
      chk(cpu_hit == 1'b1 && saw_miss == 1'b0, "R2 hit flags", {30'b0, cpu_hit, saw_miss}, 32'h2);
    end else begin
      chk(n == MISS_LAT, "R3 miss latency", 32'(n), 32'(MISS_LAT));
      chk(cpu_hit == 1'b0 && saw_miss == 1'b1, "R3 miss flags", {30'b0, cpu_hit, saw_miss}, 32'h1);
    end
    chk(stall_ok && !cpu_stall, "R10 stall", {31'b0, stall_ok}, 32'h1);
    if (!we) begin
      exp_data = isb ? sext8(ref_mem[widx], lane) : ref_mem[widx];
      chk(cpu_rdata == exp_data, rq, cpu_rdata, exp_data);
    end
    ref_v[idx] = 1'b1;
    ref_t[idx] = tg;
    if (we) begin
      if (isb) begin
        logic [31:0] m;
        m = 32'hFF << (8 * lane);
        ref_mem[widx] = (ref_mem[widx] & ~m) | ((32'(wd[7:0]) << (8 * lane)) & m);
      end else begin
        ref_mem[widx] = wd;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) ref_mem[i] = seed_word(i);
    for (int i = 0; i < NLINES; i++) begin ref_v[i] = 1'b0; ref_t[i] = 0; end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: idle outputs after reset
    chk(cpu_stall == 1'b0 && cpu_done == 1'b0, "R1 idle after reset",
        {30'b0, cpu_stall, cpu_done}, 32'h0);

    // R1/R3: first access misses; R2: same word and same line then hit.
    do_acc(1'b0, 1'b0, 'h040, '0, "R1 first load data");
    do_acc(1'b0, 1'b0, 'h040, '0, "R2 hit load data");
    do_acc(1'b0, 1'b0, 'h044, '0, "R2 same line word");
    // R6: byte loads across lanes, including negative bytes.
    for (int l = 0; l < 4; l++) do_acc(1'b0, 1'b1, 'h048 + l, '0, "R6 byte load");
    do_acc(1'b0, 1'b1, 'h3F3, '0, "R6 byte load high word");
    do_acc(1'b0, 1'b1, 'h3F0, '0, "R6 byte load lane0");
    // R9: low address bits ignored on word access.
    do_acc(1'b0, 1'b0, 'h04E, '0, "R9 word ignores low bits");
    // R5: conflict in index 4, then a different index coexists.
    do_acc(1'b0, 1'b0, 'h0C0, '0, "R5 conflict load");
    do_acc(1'b0, 1'b0, 'h040, '0, "R5 conflict back");
    do_acc(1'b0, 1'b0, 'h050, '0, "R5 other index");
    do_acc(1'b0, 1'b0, 'h044, '0, "R5 other index kept line");
    // R7: byte store touches one byte only.
    do_acc(1'b1, 1'b1, 'h041, 32'h1234_5680, "R7 byte store");
    do_acc(1'b0, 1'b0, 'h040, '0, "R7 merged word");
    do_acc(1'b0, 1'b0, 'h044, '0, "R7 neighbour word");
    do_acc(1'b0, 1'b1, 'h041, '0, "R7 stored byte signed");
    // R8: store miss allocates, survives eviction.
    do_acc(1'b1, 1'b0, 'h204, 32'hDEAD_BEEF, "R8 store miss");
    do_acc(1'b1, 1'b1, 'h20B, 32'h0000_007E, "R8 byte store hit");
    do_acc(1'b0, 1'b0, 'h004, '0, "R8 evict");
    do_acc(1'b0, 1'b0, 'h204, '0, "R8 refilled word");
    do_acc(1'b0, 1'b0, 'h208, '0, "R8 refilled byte word");

    // Constrained random mix over four tags.
    for (int k = 0; k < 400; k++) begin
      int a;
      bit w, b;
      a = int'(($urandom % 4) * 128 + ($urandom % 128));
      w = ($urandom % 3) == 0;
      b = ($urandom % 2) == 0;
      do_acc(w, b, a, $urandom, b ? "R6 random byte load" : "R9 random word load");
    end

    @(negedge clk);
    cpu_valid = 1'b0;
    @(negedge clk); #1;
    chk(cpu_done == 1'b0 && cpu_stall == 1'b0, "R10 idle at end",
        {30'b0, cpu_done, cpu_stall}, 32'h0);
    finish_run();
  end

endmodule